// File: doc/BRIEF.md
# Configurable Slave Burst Disconnect Monitor

This block sits beside the target state machine of a PCI slave and tracks the byte address of a linear burst while its data phases complete. When the data phase now in progress is the last one before an address boundary, the block raises a disconnect request. The target state machine can then finish that transfer with a STOP-with-data termination, so the burst never crosses the boundary.

The boundary is chosen at run time. A 2-bit size field selects 128, 256, 512 or 1024 bytes. A separate line-mode switch overrides the field and forces a 16-byte boundary. The monitor reloads its address on every address phase. It goes idle once the disconnecting transfer completes.

Top module: `burstStopMon`

## Requirements
- R1: While reset is asserted, and after it is released until the first address phase, `stopReq` is 0.
- R2: With `lineMode` = 0, `boundSel` selects the boundary size: 2'b00 = 128 B, 2'b01 = 256 B, 2'b10 = 512 B, 2'b11 = 1024 B.
- R3: With `lineMode` = 1, the boundary is 16 B whatever `boundSel` holds.
- R4: `stopReq` is 1 during exactly the data phase whose address is the last DWORD before a boundary, meaning that address + 4 has its low log2(boundary) bits all zero. It is 0 in the earlier phases.
- R5: The tracked address advances by 4 bytes only on a cycle with `phaseDone` = 1, so a burst starting at byte offset s within its boundary block reaches the disconnect on data phase (boundary − s)/4.
- R6: A burst whose start address is the last DWORD of a boundary block raises `stopReq` in its first data phase, in the cycle right after the address phase.
- R7: After a data phase completes with `stopReq` = 1, the monitor is idle and `stopReq` stays 0 until the next address phase.
- R8: An address phase (`addrValid` = 1) restarts the monitor from the new `startAddr`, even in the middle of a burst.
- R9: `phaseDone` while the monitor is idle has no effect: `stopReq` stays 0.
- R10: Bits [1:0] of `startAddr` are ignored, and the burst is tracked from the DWORD that contains the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrValid | input | 1 | Address-phase strobe; loads `startAddr` |
| startAddr | input | ADDR_W | Burst start byte address |
| phaseDone | input | 1 | A data phase completes this cycle |
| boundSel | input | 2 | Boundary size select (128/256/512/1024 B) |
| lineMode | input | 1 | 1 = force the 16-byte line boundary |
| stopReq | output | 1 | Disconnect with the current data phase |

## Verification
The assertions take for granted that `boundSel` and `lineMode` do not change inside a burst. They also assume `addrValid` and `phaseDone` never rise together, because an address phase carries no data. The properties that rely on stable configuration allow for a change explicitly. The bench changes configuration only while `addrValid` is being driven, and it never drives both strobes in the same cycle. It sweeps every select value, both modes and start offsets at the edges of each boundary block.

// File: rtl/burstStopPkg.sv
package burstStopPkg;
  typedef struct packed {
    logic load;     // address phase: reload address, enter active
    logic advance;  // data phase completed while active
  } ctlStrobeT;
endpackage

// File: rtl/burstStopDp.sv
module burstStopDp #(
  parameter int ADDR_W     = 32,
  parameter int BASE_BYTES = 128,
  parameter int LINE_BYTES = 16,
  parameter int SEL_W      = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  burstStopPkg::ctlStrobeT  ctl,
  input  logic [ADDR_W-1:0]        startAddr,
  input  logic [SEL_W-1:0]         boundSel,
  input  logic                     lineMode,
  output logic                     boundHit
);
  localparam int SEL_COUNT = 1 << SEL_W;
  localparam int STEP      = 4;

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] maskTab [SEL_COUNT];
  logic [ADDR_W-1:0] activeMask;

  for (genvar i = 0; i < SEL_COUNT; i++) begin : g_mask
    assign maskTab[i] = ADDR_W'((BASE_BYTES << i) - 1);
  end

  assign activeMask = lineMode ? ADDR_W'(LINE_BYTES - 1) : maskTab[boundSel];
  assign nextAddr   = curAddr + ADDR_W'(STEP);
  assign boundHit   = ((nextAddr & activeMask) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (ctl.load) begin
      curAddr <= {startAddr[ADDR_W-1:2], 2'b00};
    end else if (ctl.advance) begin
      curAddr <= nextAddr;
    end
  end
endmodule

// File: rtl/burstStopCtl.sv
module burstStopCtl (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     addrValid,
  input  logic                     phaseDone,
  input  logic                     boundHit,
  output burstStopPkg::ctlStrobeT  ctl,
  output logic                     stopReq
);
  typedef enum logic {IDLE, ACTIVE} stateT;
  stateT state;

  always_comb begin
    ctl.load    = addrValid;
    ctl.advance = phaseDone && !addrValid && (state == ACTIVE);
  end

  assign stopReq = (state == ACTIVE) && boundHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
    end else if (ctl.load) begin
      state <= ACTIVE;
    end else if (ctl.advance && boundHit) begin
      state <= IDLE;
    end
  end
endmodule

// File: rtl/burstStopMon.sv
module burstStopMon #(
  parameter int ADDR_W     = 32,
  parameter int BASE_BYTES = 128,
  parameter int LINE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              phaseDone,
  input  logic [1:0]        boundSel,
  input  logic              lineMode,
  output logic              stopReq
);
  burstStopPkg::ctlStrobeT ctl;
  logic boundHit;

  burstStopCtl u_ctl (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .phaseDone(phaseDone),
    .boundHit(boundHit), .ctl(ctl), .stopReq(stopReq)
  );

  burstStopDp #(
    .ADDR_W(ADDR_W), .BASE_BYTES(BASE_BYTES), .LINE_BYTES(LINE_BYTES), .SEL_W(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr),
    .boundSel(boundSel), .lineMode(lineMode), .boundHit(boundHit)
  );
endmodule

// File: rtl/burstStopMonChk.sv
module burstStopMonChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrValid,
  input logic [ADDR_W-1:0] startAddr,
  input logic              phaseDone,
  input logic [1:0]        boundSel,
  input logic              lineMode,
  input logic              stopReq
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |-> !stopReq);

  // R7
  stop_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && phaseDone && !addrValid) |=> !stopReq);

  // R5
  hold_without_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!phaseDone && !addrValid) |=>
      ($stable(stopReq) || !$stable(boundSel) || !$stable(lineMode)));

  // R3
  line_last_dword_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && lineMode && startAddr[3:2] == 2'b11) |=>
      (stopReq || !$stable(lineMode)));

  // R6
  first_phase_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !lineMode && boundSel == 2'b00 && startAddr[6:2] == 5'h1f) |=>
      (stopReq || !$stable(lineMode) || !$stable(boundSel)));
endmodule

bind burstStopMon burstStopMonChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .addrValid(addrValid), .startAddr(startAddr),
  .phaseDone(phaseDone), .boundSel(boundSel), .lineMode(lineMode), .stopReq(stopReq)
);

// File: tb/sim_burstStopMon.sv
module sim_burstStopMon;
  logic        clk = 0;
  logic        rstN = 0;
  logic        addrValid = 0;
  logic [31:0] startAddr = '0;
  logic        phaseDone = 0;
  logic [1:0]  boundSel = '0;
  logic        lineMode = 0;
  logic        stopReq;
  int          nRun = 0;
  int          nFail = 0;
  bit          done = 0;

  always #2 clk = ~clk;  // 250 MHz

  burstStopMon u0 (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .startAddr(startAddr),
    .phaseDone(phaseDone), .boundSel(boundSel), .lineMode(lineMode), .stopReq(stopReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadAddr(input logic [1:0] sel, input bit lm, input logic [31:0] a);
    @(negedge clk);
    boundSel = sel; lineMode = lm; startAddr = a; addrValid = 1;
    @(negedge clk);
    addrValid = 0;
  endtask

  // Runs data phases; returns index of first phase with stopReq (0 if none within maxN)
  task automatic runPhases(input int maxN, output int firstStop);
    firstStop = 0;
    for (int k = 1; k <= maxN; k++) begin
      if (stopReq && firstStop == 0) firstStop = k;
      phaseDone = 1;
      @(negedge clk);
      phaseDone = 0;
      if (firstStop != 0) break;
    end
  endtask

  task automatic burst(input logic [1:0] sel, input bit lm, input logic [31:0] a, input string req);
    int bound, expN, got;
    bound = lm ? 16 : (128 << sel);
    expN  = (bound - (int'(a[9:0] & 10'h3fc) % bound)) / 4;
    loadAddr(sel, lm, a);
    runPhases(300, got);
    check(got == expN, req, got, expN);
    // R7: idle after disconnect
    check(stopReq == 0, "R7", int'(stopReq), 0);
    // R9: phases while idle do nothing
    for (int j = 0; j < 3; j++) begin
      phaseDone = 1; @(negedge clk); phaseDone = 0;
    end
    check(stopReq == 0, "R9", int'(stopReq), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int got;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(stopReq == 0, "R1 in reset", int'(stopReq), 0);
    rstN = 1;
    @(negedge clk);
    check(stopReq == 0, "R1 after reset", int'(stopReq), 0);
    // R9: phases before any address phase
    for (int j = 0; j < 4; j++) begin
      phaseDone = 1; @(negedge clk); phaseDone = 0;
    end
    check(stopReq == 0, "R9 idle phases", int'(stopReq), 0);

    // R2/R4/R5/R6/R10: boundary field sweep
    for (int s = 0; s < 4; s++) begin
      int b;
      b = 128 << s;
      burst(2'(s), 0, 32'h1000_0000 + 32'(s * 4096), "R2 R4 R5 start aligned");
      burst(2'(s), 0, 32'h2000_0000 + 32'(b - 4), "R6 last dword");
      burst(2'(s), 0, 32'h3000_0000 + 32'(b - 8), "R4 two phases");
      burst(2'(s), 0, 32'h4000_0000 + 32'(b + 38), "R10 unaligned low bits");
      burst(2'(s), 0, 32'h5000_0000 + 32'(b / 2 + 4), "R5 mid block");
    end
    // R3: line mode overrides the select field
    for (int s = 0; s < 4; s++) begin
      burst(2'(s), 1, 32'h6000_0000 + 32'(s * 64), "R3 line aligned");
      burst(2'(s), 1, 32'h6000_000c + 32'(s * 64), "R3 R6 line last dword");
      burst(2'(s), 1, 32'h6000_0006 + 32'(s * 64), "R3 R10 line unaligned");
    end

    // R8: restart mid-burst
    loadAddr(2'b00, 0, 32'h7000_0000);
    for (int j = 0; j < 5; j++) begin
      phaseDone = 1; @(negedge clk); phaseDone = 0;
    end
    loadAddr(2'b00, 0, 32'h7000_0070);
    runPhases(300, got);
    check(got == 4, "R8 restart", got, 4);
    // R8: restart right after a disconnect, on a different size
    loadAddr(2'b01, 0, 32'h7000_00f8);
    runPhases(300, got);
    check(got == 2, "R8 reload after stop", got, 2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule